// File: doc/BRIEF.md
# Windowed Keyed-Refresh Watchdog

This block is a supervision counter that a system places beside a processor so that software which stops running its main loop is caught. An up-counter advances on a tick picked from four enable sources: every bus cycle, a 1 kHz pulse, a 32 kHz pulse or an external pulse. The slow sources come in as single-cycle enable pulses already in the bus clock domain. A fixed divide-by-256 stage can be placed in front of the counter to stretch the period. When the count reaches a 16-bit limit, the block ends the run. It either pulses its reset output at once, or it first raises a sticky interrupt and pulses reset a fixed 128 bus cycles later.

Software keeps the counter away from the limit by writing a two-word key through a simple strobe and data port. The pair restarts the count. A second word that is wrong or late is treated as a runaway program and resets the system at once. An optional lower window does the same to a refresh that arrives too early. After it has fired, the block stays silent until its own reset.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst`, `wd_irq` and `wd_reset` are both low, the counter and the divider are zero, and no key is pending.
- R2: With `cfg_src` = 0 (every bus cycle), no divider and `cfg_irq_en` low, `wd_reset` is high for exactly one cycle. It is registered T+1 cycles after counting starts from zero, where T is `cfg_timeout`.
- R3: `cfg_src` selects the count tick: 0 every bus cycle, 1 `tick_1k`, 2 `tick_32k`, 3 `tick_ext`. Pulses on the unselected inputs have no effect.
- R4: With `cfg_prescale` high, the counter advances once per 256 selected ticks, so with bus ticks the reset comes 256*T+1 cycles after counting starts.
- R5: A refresh is the word 0x02A6 followed, 1 to 16 bus cycles later, by the word 0x80B4. It clears both the counter and the divider to zero.
- R6: If no second word has arrived 16 cycles after a first word 0x02A6, `wd_reset` pulses in the cycle that follows that 16th cycle.
- R7: A second word other than 0x80B4 pulses `wd_reset` in the cycle after that write.
- R8: While no key is pending, a written word other than 0x02A6 has no effect.
- R9: With `cfg_window_en` high, a refresh that completes while the count is below `cfg_window` pulses `wd_reset` in the next cycle. A count equal to or above the window refreshes normally.
- R10: With `cfg_irq_en` high, reaching the limit sets `wd_irq` one cycle after the match. `wd_irq` then stays high until `rst`, and `wd_reset` pulses exactly 128 cycles after `wd_irq` rises.
- R11: While `cfg_enable` is low, the counter holds at zero, key writes are ignored, and neither output is raised. Counting resumes from zero once it is set.
- R12: After `wd_reset` has pulsed, further writes and ticks produce no more interrupt or reset until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Watchdog running |
| cfg_src | input | 2 | Tick source select (0 bus, 1 1 kHz, 2 32 kHz, 3 external) |
| cfg_prescale | input | 1 | Insert the divide-by-256 stage |
| cfg_irq_en | input | 1 | Interrupt first, reset 128 cycles later |
| cfg_window_en | input | 1 | Enable the early-refresh fault |
| cfg_timeout | input | 16 | Count limit |
| cfg_window | input | 16 | Lowest count at which a refresh is accepted |
| tick_1k | input | 1 | 1 kHz enable pulse |
| tick_32k | input | 1 | 32 kHz enable pulse |
| tick_ext | input | 1 | External enable pulse |
| wr_stb | input | 1 | Key write strobe |
| wr_data | input | 16 | Key write word |
| wd_irq | output | 1 | Sticky timeout interrupt |
| wd_reset | output | 1 | One-cycle system reset pulse |

## Verification
Internal state is only visible through the timing of the two outputs. A counter or divider that is off by one, or that fails to clear, moves the reset pulse by one or by 256 cycles. Because the bench compares the exact cycle of every pulse, such an error is reported at the first expected event. A key tracker that arms on the wrong word, or counts its deadline wrongly, produces a reset that nobody expected or that comes one cycle early or late. The window scenarios put a refresh one count below the window and one at the window, so a flipped comparison shows up as a missing or extra pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // tick source encoding, used as an index into the source vector
    typedef enum logic [1:0] {
        SRC_BUS = 2'd0,
        SRC_1K  = 2'd1,
        SRC_32K = 2'd2,
        SRC_EXT = 2'd3
    } wdt_src_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IRQ  = 2'd1,
        ST_TRIP = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic ok;   // valid pair completed this cycle
        logic bad;  // wrong or late second word
    } key_res_t;

    localparam logic [15:0] KEY_FIRST  = 16'h02A6;
    localparam logic [15:0] KEY_SECOND = 16'h80B4;

    function automatic logic too_early(input logic win_en,
                                       input logic [15:0] cnt,
                                       input logic [15:0] win);
        return win_en && (cnt < win);
    endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       pre_en,
    input  logic       tick_1k,
    input  logic       tick_32k,
    input  logic       tick_ext,
    output logic       adv
);
    logic [3:0] src;
    logic       tick;

    assign src  = {tick_ext, tick_32k, tick_1k, 1'b1};
    assign tick = run && src[sel];

    generate
        if (PRE_W > 0) begin : g_pre
            logic [PRE_W-1:0] pre;

            always_ff @(posedge clk) begin
                if (rst || clr)
                    pre <= '0;
                else if (tick && pre_en)
                    pre <= pre + 1'b1;
            end

            assign adv = tick && (!pre_en || (&pre));

            // R4
            pre_step_chk: assert property (@(posedge clk) disable iff (rst)
                (tick && pre_en && !clr) |=> (pre == $past(pre) + 1'b1));
        end else begin : g_nopre
            assign adv = tick;
        end
    endgenerate

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         hit
);
    assign hit = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv && !hit)
            cnt <= cnt + 1'b1;
    end

    // R11
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && adv && !hit) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/wdt_key.sv
module wdt_key #(
    parameter int          KEY_W   = 16,
    parameter int          KEY_GAP = 16,
    parameter logic [15:0] KEY_A   = 16'h02A6,
    parameter logic [15:0] KEY_B   = 16'h80B4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              stb,
    input  logic [KEY_W-1:0]  data,
    output wdt_pkg::key_res_t res
);
    localparam int             GAP_W = (KEY_GAP > 1) ? $clog2(KEY_GAP) : 1;
    localparam logic [GAP_W-1:0] LAST = GAP_W'(KEY_GAP - 1);

    logic             armed;
    logic [GAP_W-1:0] gap;

    always_comb begin
        res = '0;
        if (en && armed) begin
            if (stb) begin
                if (data == KEY_W'(KEY_B)) res.ok  = 1'b1;
                else                       res.bad = 1'b1;
            end else if (gap == LAST) begin
                res.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            armed <= 1'b0;
            gap   <= '0;
        end else if (armed) begin
            if (stb || gap == LAST) armed <= 1'b0;
            else                    gap   <= gap + 1'b1;
        end else if (stb && data == KEY_W'(KEY_A)) begin
            armed <= 1'b1;
            gap   <= '0;
        end
    end

    // R5
    key_done_chk: assert property (@(posedge clk) disable iff (rst)
        res.ok |=> !armed);

    // R6
    key_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (en && armed && !stb && gap != LAST) |=> armed);

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
    parameter int TMR_W     = 16,
    parameter int PRE_W     = 8,
    parameter int KEY_W     = 16,
    parameter int KEY_GAP   = 16,
    parameter int IRQ_DELAY = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_src,
    input  logic             cfg_prescale,
    input  logic             cfg_irq_en,
    input  logic             cfg_window_en,
    input  logic [TMR_W-1:0] cfg_timeout,
    input  logic [TMR_W-1:0] cfg_window,
    input  logic             tick_1k,
    input  logic             tick_32k,
    input  logic             tick_ext,
    input  logic             wr_stb,
    input  logic [KEY_W-1:0] wr_data,
    output logic             wd_irq,
    output logic             wd_reset
);
    import wdt_pkg::*;

    localparam int               DLY_W  = $clog2(IRQ_DELAY);
    localparam logic [DLY_W-1:0] DLY_END = DLY_W'(IRQ_DELAY - 1);

    wdt_state_e       state;
    logic [DLY_W-1:0] dly;
    logic [TMR_W-1:0] cnt;
    key_res_t         kres;
    logic             run, adv, hit, early, good_ref, clr;
    logic             expire, trip_now, irq_go;

    assign run      = cfg_enable && (state == ST_RUN);
    assign early    = kres.ok && (cnt < cfg_window) && cfg_window_en;
    assign good_ref = kres.ok && !early;
    assign clr      = good_ref || !cfg_enable;
    assign expire   = run && hit && !good_ref;
    assign trip_now = run && (kres.bad || early || (expire && !cfg_irq_en));
    assign irq_go   = expire && cfg_irq_en && !kres.bad && !early;

    wdt_key #(
        .KEY_W(KEY_W), .KEY_GAP(KEY_GAP),
        .KEY_A(KEY_FIRST), .KEY_B(KEY_SECOND)
    ) u_key (
        .clk(clk), .rst(rst), .en(run),
        .stb(wr_stb), .data(wr_data), .res(kres)
    );

    wdt_tick_sel #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst(rst), .clr(clr), .run(run),
        .sel(cfg_src), .pre_en(cfg_prescale),
        .tick_1k(tick_1k), .tick_32k(tick_32k), .tick_ext(tick_ext),
        .adv(adv)
    );

    wdt_count #(.W(TMR_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .adv(adv),
        .limit(cfg_timeout), .cnt(cnt), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            dly      <= '0;
            wd_irq   <= 1'b0;
            wd_reset <= 1'b0;
        end else begin
            wd_reset <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (trip_now) begin
                        state    <= ST_TRIP;
                        wd_reset <= 1'b1;
                    end else if (irq_go) begin
                        state  <= ST_IRQ;
                        wd_irq <= 1'b1;
                        dly    <= '0;
                    end
                end
                ST_IRQ: begin
                    dly <= dly + 1'b1;
                    if (dly == DLY_END) begin
                        state    <= ST_TRIP;
                        wd_reset <= 1'b1;
                    end
                end
                default: state <= ST_TRIP;
            endcase
        end
    end

    // R2
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wd_reset |=> !wd_reset);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wd_irq |=> wd_irq);

    // R10
    irq_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_irq) |-> !wd_reset);

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && state == ST_RUN) |=> !wd_reset);

    // R12
    trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRIP) |=> (state == ST_TRIP && !wd_reset));

endmodule

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b1;
    logic [1:0]  cfg_src = 2'd0;
    logic        cfg_prescale = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        cfg_window_en = 1'b0;
    logic [15:0] cfg_timeout = 16'd20;
    logic [15:0] cfg_window = 16'd0;
    logic        tick_1k = 1'b0, tick_32k = 1'b0, tick_ext = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        wd_irq, wd_reset;

    localparam logic [15:0] K1 = 16'h02A6;
    localparam logic [15:0] K2 = 16'h80B4;

    always #2 clk = ~clk;

    wdt_keyed u_wdt_keyed (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_src(cfg_src),
        .cfg_prescale(cfg_prescale), .cfg_irq_en(cfg_irq_en),
        .cfg_window_en(cfg_window_en), .cfg_timeout(cfg_timeout),
        .cfg_window(cfg_window), .tick_1k(tick_1k), .tick_32k(tick_32k),
        .tick_ext(tick_ext), .wr_stb(wr_stb), .wr_data(wr_data),
        .wd_irq(wd_irq), .wd_reset(wd_reset)
    );

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    int    c0 = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    logic  irq_prev = 1'b0;

    // scoreboard: kind 0 = interrupt rise, 1 = reset pulse
    int    q_kind[$];
    int    q_at[$];
    string q_req[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic note(input int kind);
        checks++;
        if (q_kind.size() == 0) begin
            fails++;
            $display("FAIL %s: unexpected event kind %0d at cycle %0d, expected none",
                     cur_req, kind, cyc);
        end else begin
            int    k  = q_kind.pop_front();
            int    at = q_at.pop_front();
            string r  = q_req.pop_front();
            if (k != kind || at != cyc) begin
                fails++;
                $display("FAIL %s: event kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                         r, kind, cyc, k, at);
            end
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst) begin
            irq_prev = 1'b0;
        end else begin
            if (wd_irq && !irq_prev) note(0);
            if (wd_reset) note(1);
            irq_prev = wd_irq;
        end
    end

    task automatic exp_ev(input int kind, input int at);
        q_kind.push_back(kind);
        q_at.push_back(at);
        q_req.push_back(cur_req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_stb = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        c0 = cyc;
    endtask

    task automatic wr1(input logic [15:0] w);
        wr_stb = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // first word now, second word d cycles later
    task automatic key_pair(input int d, input logic [15:0] w2);
        wr_stb = 1'b1;
        wr_data = K1;
        repeat (d) @(negedge clk) wr_stb = 1'b0;
        wr1(w2);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        checks++;
        if (q_kind.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected events missing, expected 0 (next at cycle %0d)",
                     cur_req, q_kind.size(), q_at[0]);
            q_kind.delete();
            q_at.delete();
            q_req.delete();
        end
    endtask

    task automatic chk_idle(input string r);
        checks++;
        if (wd_irq !== 1'b0 || wd_reset !== 1'b0) begin
            fails++;
            $display("FAIL %s: irq=%b reset=%b, expected irq=0 reset=0", r, wd_irq, wd_reset);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        do_reset();
        chk_idle("R1");
        settle(0);

        // R2: plain timeout on bus ticks
        cur_req = "R2";
        cfg_timeout = 16'd20;
        do_reset();
        exp_ev(1, c0 + 21);
        settle(30);

        // R12: tripped block ignores keys and stays quiet
        cur_req = "R12";
        wr1(K1);
        repeat (3) @(negedge clk);
        wr1(16'h0000);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (wd_reset || wd_irq) seen = 1'b1;
            end
            checks++;
            if (seen) begin
                fails++;
                $display("FAIL R12: output activity after trip = 1, expected 0");
            end
        end
        settle(0);

        // R10: interrupt then delayed reset
        cur_req = "R10";
        cfg_timeout = 16'd10;
        cfg_irq_en = 1'b1;
        do_reset();
        exp_ev(0, c0 + 11);
        exp_ev(1, c0 + 139);
        settle(150);
        checks++;
        if (wd_irq !== 1'b1) begin
            fails++;
            $display("FAIL R10: irq after reset pulse = %b, expected 1", wd_irq);
        end
        cur_req = "R1";
        do_reset();
        chk_idle("R1");
        cfg_irq_en = 1'b0;

        // R4: divide-by-256
        cur_req = "R4";
        cfg_prescale = 1'b1;
        cfg_timeout = 16'd3;
        do_reset();
        exp_ev(1, c0 + 769);
        settle(780);

        // R5: refresh clears the divider too
        cur_req = "R5";
        cfg_timeout = 16'd2;
        do_reset();
        repeat (100) @(negedge clk);
        key_pair(1, K2);
        exp_ev(1, cyc + 513);
        settle(530);
        cfg_prescale = 1'b0;

        // R3: slow tick sources, unselected lines toggling
        cur_req = "R3";
        cfg_timeout = 16'd4;
        for (int s = 1; s < 4; s++) begin
            cfg_src = 2'(s);
            tick_1k  = (s != 1);
            tick_32k = (s != 2);
            tick_ext = (s != 3);
            do_reset();
            for (int i = 0; i < 4; i++) begin
                repeat (3) @(negedge clk);
                if (i == 3) exp_ev(1, cyc + 2);
                case (s)
                    1: tick_1k = 1'b1;
                    2: tick_32k = 1'b1;
                    default: tick_ext = 1'b1;
                endcase
                @(negedge clk);
                case (s)
                    1: tick_1k = 1'b0;
                    2: tick_32k = 1'b0;
                    default: tick_ext = 1'b0;
                endcase
            end
            settle(10);
        end
        tick_1k = 1'b0;
        tick_32k = 1'b0;
        tick_ext = 1'b0;
        cfg_src = 2'd0;

        // R5: valid refresh at the 16-cycle deadline
        cur_req = "R5";
        cfg_timeout = 16'd60;
        do_reset();
        repeat (20) @(negedge clk);
        key_pair(16, K2);
        exp_ev(1, cyc + 61);
        settle(75);

        // R6: second word one cycle too late
        cur_req = "R6";
        do_reset();
        repeat (5) @(negedge clk);
        exp_ev(1, cyc + 17);
        key_pair(17, K2);
        settle(10);

        // R7: wrong second word
        cur_req = "R7";
        do_reset();
        repeat (5) @(negedge clk);
        exp_ev(1, cyc + 4);
        key_pair(3, 16'h1234);
        settle(10);

        // R8: stray words without a pending key
        cur_req = "R8";
        cfg_timeout = 16'd25;
        do_reset();
        exp_ev(1, c0 + 26);
        repeat (3) @(negedge clk);
        wr1(16'h1111);
        wr1(K2);
        settle(35);

        // R9: window, early, boundary below and at window
        cur_req = "R9";
        cfg_window_en = 1'b1;
        cfg_window = 16'd10;
        cfg_timeout = 16'd40;
        do_reset();
        exp_ev(1, c0 + 2);
        key_pair(1, K2);
        settle(10);
        do_reset();
        repeat (8) @(negedge clk);
        exp_ev(1, c0 + 10);
        key_pair(1, K2);
        settle(10);
        do_reset();
        repeat (9) @(negedge clk);
        exp_ev(1, c0 + 52);
        key_pair(1, K2);
        settle(50);
        cfg_window_en = 1'b0;

        // R11: disabled holds at zero and ignores keys
        cur_req = "R11";
        cfg_timeout = 16'd5;
        cfg_enable = 1'b0;
        do_reset();
        wr1(K1);
        repeat (300) @(negedge clk);
        chk_idle("R11");
        exp_ev(1, cyc + 6);
        cfg_enable = 1'b1;
        settle(15);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule